// File: doc/BRIEF.md
# Fast Peripheral Clock Enable Control Register

This block is a single byte-wide control and status register that sequences the start-up of a PLL-derived fast peripheral clock and the hand-over of a timer onto that clock. Software writes it over a simple address/data port and reads it back combinationally. The register drives four control lines: the PLL enable, a divide-by-two (low-speed) select for the fast clock, the timer clock-source select, and a lock indication.

The analog PLL and the clock multiplexer are not part of the block. A cycle counter clocked by the system clock stands in for the lock detector: lock is reported a fixed number of cycles after the PLL enable rises. Write-side interlocks make the intended sequence the only one that works: the PLL must be running before the timer can be moved onto the fast clock, and stopping the PLL drops both the lock indication and the fast-clock selection at once. A strap input marks the PLL as the system clock source, in which case the PLL enable is held on.

Top module: `fastclk_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and all outputs are low, except that the PLL enable (bit 1) reads 1 and `pll_en_o` is high when `pll_sysclk_strap_i` is high.
- R2: Bits 6 to 3 always read as zero; writing ones to them has no effect on any output or on the readback.
- R3: Bit 0 (lock) is read-only: the value written to bit 0 never changes the lock indication.
- R4: Bit 2 (timer fast-clock select) is set by a write only if bit 1 (PLL enable) was already 1 before that write; a write setting bits 1 and 2 together from a PLL-off state leaves bit 2 at 0.
- R5: `lock_o` and bit 0 go high exactly LOCK_CYCLES clock edges after the edge that registers the PLL enable as 1, and the count restarts from zero every time the enable rises again.
- R6: Bit 7 is read/write and drives `half_rate_o` (1 = fast clock divided by two).
- R7: While `pll_sysclk_strap_i` is high, bit 1 reads 1 and `pll_en_o` stays high whatever is written to bit 1.
- R8: `tmr_fast_sel_o` follows bit 2: 0 selects the system clock for the timer, 1 selects the fast PLL clock.
- R9: A write that clears bit 1 clears bit 2 and the lock indication from the same clock edge.
- R10: Writes take effect only when `addr_i` equals REG_ADDR; `rdata_o` is 0x00 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pll_sysclk_strap_i | input | 1 | High when the PLL is the system clock source |
| wr_en_i | input | 1 | Write strobe, sampled on the rising clock edge |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| pll_en_o | output | 1 | PLL enable |
| half_rate_o | output | 1 | Fast clock divide-by-two select |
| tmr_fast_sel_o | output | 1 | Timer clock source: 0 system clock, 1 fast clock |
| lock_o | output | 1 | PLL lock indication from the lock timer |

## Verification
The hardest situation to reach is a PLL enable that drops and rises again after lock, where the lock count must start over rather than resume, and the moment of lock must be hit on exactly the right edge. The stimulus enables the PLL, samples the lock bit after every edge up to and past the limit, then clears and re-enables it partway through a second count and samples edge by edge again. The interlock on the fast-clock select is reached by a single write that sets both bits from a PLL-off state, followed by the same write once the PLL is on.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
    localparam int DATA_W   = 8;
    localparam int BIT_HALF = 7;
    localparam int BIT_FAST = 2;
    localparam int BIT_PLL  = 1;
    localparam int BIT_LOCK = 0;

    typedef struct packed {
        logic half;
        logic fast;
        logic pll;
    } ctrl_t;
endpackage

// File: rtl/fcr_lock_timer.sv
module fcr_lock_timer #(
    parameter int LOCK_CYCLES = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic lock_o
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en_i) begin
            cnt_d = '0;
        end else if (cnt_q == LIMIT) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign lock_o = en_i && (cnt_q == LIMIT);

    // R5: the count always starts from zero when the enable rises
    assert_lock_low_on_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |-> !lock_o);

    // R5: lock only appears while enabled through the previous cycle too
    assert_lock_needs_prior_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(en_i));
endmodule

// File: rtl/fcr_readback.sv
module fcr_readback
    import fcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  ctrl_t             ctrl_i,
    input  logic              lock_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] word;

    always_comb begin
        word           = '0;
        word[BIT_HALF] = ctrl_i.half;
        word[BIT_FAST] = ctrl_i.fast;
        word[BIT_PLL]  = ctrl_i.pll;
        word[BIT_LOCK] = lock_i;
        rdata_o        = sel_i ? word : '0;
    end

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[BIT_HALF-1:BIT_FAST+1] == '0);

    assert_unselected_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |-> (rdata_o == '0));
endmodule

// File: rtl/fastclk_ctrl.sv
module fastclk_ctrl
    import fcr_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 4'h7,
    parameter int                LOCK_CYCLES = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_sysclk_strap_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              pll_en_o,
    output logic              half_rate_o,
    output logic              tmr_fast_sel_o,
    output logic              lock_o
);
    ctrl_t ctrl_d, ctrl_q;
    logic  sel;
    logic  lock;

    assign sel = (addr_i == REG_ADDR);

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.pll = ctrl_q.pll | pll_sysclk_strap_i;
        if (wr_en_i && sel) begin
            ctrl_d.half = wdata_i[BIT_HALF];
            ctrl_d.pll  = wdata_i[BIT_PLL] | pll_sysclk_strap_i;
            ctrl_d.fast = wdata_i[BIT_FAST] & ctrl_q.pll;
        end
        if (!ctrl_d.pll) begin
            ctrl_d.fast = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.half <= 1'b0;
            ctrl_q.fast <= 1'b0;
            ctrl_q.pll  <= pll_sysclk_strap_i;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    fcr_lock_timer #(
        .LOCK_CYCLES(LOCK_CYCLES)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl_q.pll),
        .lock_o (lock)
    );

    fcr_readback u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel),
        .ctrl_i  (ctrl_q),
        .lock_i  (lock),
        .rdata_o (rdata_o)
    );

    assign pll_en_o       = ctrl_q.pll;
    assign half_rate_o    = ctrl_q.half;
    assign tmr_fast_sel_o = ctrl_q.fast;
    assign lock_o         = lock;

    assert_fast_needs_pll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_fast_sel_o |-> pll_en_o);

    assert_fast_rise_after_pll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_fast_sel_o) |-> $past(pll_en_o));

    assert_strap_holds_pll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_sysclk_strap_i |-> pll_en_o);

    assert_pll_off_drops_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en_o) |-> (!lock_o && !tmr_fast_sel_o));
endmodule

// File: tb/fastclk_ctrl_tb.sv
module fastclk_ctrl_tb;
    localparam int          LOCK = 16;
    localparam logic [3:0]  REG  = 4'h7;
    localparam logic [3:0]  OTH  = 4'h3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = REG;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pll_en, half, fsel, lock;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fastclk_ctrl #(.ADDR_W(4), .REG_ADDR(REG), .LOCK_CYCLES(LOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .pll_sysclk_strap_i(strap),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .pll_en_o(pll_en), .half_rate_o(half), .tmr_fast_sel_o(fsel), .lock_o(lock)
    );

    // {write data, expected readback}; strap low, PLL never on long enough to lock
    localparam logic [15:0] VEC [8] = '{
        {8'h06, 8'h02},   // R4 both bits from PLL-off: select rejected
        {8'h06, 8'h06},   // R4 R8 PLL already on: select accepted
        {8'h04, 8'h00},   // R9 PLL cleared drops select
        {8'hFF, 8'h82},   // R2 R3 R6 reserved and lock ignored, half set
        {8'hFD, 8'h80},   // R9 PLL off again
        {8'h7A, 8'h02},   // R2 R6 reserved ignored, half cleared
        {8'h86, 8'h86},   // R4 R6 select with PLL on
        {8'h00, 8'h00}    // R9 all cleared
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = REG;
    endtask

    task automatic outs_chk(input string req, input logic [7:0] exp);
        chk(req, rdata, exp);
        chk(req, {half, 4'b0, fsel, pll_en, lock},
            {exp[7], 4'b0, exp[2], exp[1], exp[0]});
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        outs_chk("R1 reset strap low", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            wr(REG, VEC[i][15:8]);
            outs_chk($sformatf("R2/R4/R6/R8/R9 vector %0d", i), VEC[i][7:0]);
        end

        // R10: other address reads zero, write there ignored
        addr = OTH; #0;
        @(negedge clk);
        chk("R10 read other address", rdata, 8'h00);
        wr(OTH, 8'h82);
        outs_chk("R10 write other address ignored", 8'h00);

        // R5: lock edge count
        wr(REG, 8'h03);
        chk("R3 lock write ignored", rdata, 8'h02);
        for (int k = 1; k <= LOCK; k++) begin
            @(negedge clk);
            if (k >= LOCK - 1)
                chk($sformatf("R5 lock after %0d edges", k), {7'b0, lock}, {7'b0, k == LOCK});
        end
        chk("R5 lock readback", rdata, 8'h03);
        wr(REG, 8'h02);
        chk("R3 lock kept when writing 0", rdata, 8'h03);
        wr(REG, 8'h06);
        outs_chk("R8 fast select with lock", 8'h07);
        wr(REG, 8'h00);
        outs_chk("R9 clear drops lock and select", 8'h00);

        // R5 restart: partial count, drop, re-enable, count again in full
        wr(REG, 8'h02);
        repeat (LOCK - 4) @(negedge clk);
        wr(REG, 8'h00);
        wr(REG, 8'h02);
        for (int k = 1; k <= LOCK; k++) begin
            @(negedge clk);
            if (k >= LOCK - 1)
                chk($sformatf("R5 restart lock after %0d edges", k), {7'b0, lock}, {7'b0, k == LOCK});
        end
        wr(REG, 8'h00);

        // R7: strap
        strap = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        outs_chk("R1 reset strap high", 8'h02);
        rst_n = 1'b1;
        @(negedge clk);
        wr(REG, 8'h80);
        chk("R7 PLL cannot be cleared", rdata & 8'hFE, 8'h82);
        chk("R7 pll_en_o held", {7'b0, pll_en}, 8'h01);
        wr(REG, 8'h04);
        chk("R4 R7 select accepted under strap", rdata & 8'hFE, 8'h06);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule